// File: doc/BRIEF.md
# Register Soft-Lock Protection Wrapper

This block is a bus slave placed between a byte-wide register bus and a peripheral's register file. It stores one soft lock bit for each register byte. A write to a locked register byte is dropped, so a register set up once during initialisation cannot be changed later by accident. Reads are never blocked by a lock.

The block decodes three address windows. The direct window reaches the register bytes. The mirror window reaches the same bytes, and a write through it also sets the lock bit of the byte it wrote. The lock window holds the lock bits. Each lock byte carries four lock bits. In a write to a lock byte, the low nibble of the write data selects which of the four lock bits may change. Only a supervisor-mode write may change the lock window.

A parameter bitmap marks which register bytes are protectable. The lock bit of a byte that is not protectable stays 0 at all times. Any access outside the three windows, and any refused write, returns an error response one cycle later.

Top module: `reg_softlock_wrap`

## Requirements
- R1: After reset every lock bit is 0. bus_err is 0 and bus_rdata is 0.
- R2: An access to an address A below NREG (the direct window) reaches register byte A. For a write, reg_wr, reg_addr=A and reg_wdata are driven in the access cycle. For a read, the value of reg_rdata appears on bus_rdata in the next cycle.
- R3: An access to MIR_BASE+n (the mirror window, default 0x2000 to 0x37FF) reaches register byte n. A write that is accepted also sets the lock bit of byte n, provided byte n is protectable.
- R4: A write to a locked register byte, through either the direct or the mirror window, does not assert reg_wr. It raises bus_err in the next cycle.
- R5: A read of a locked register byte is forwarded as usual, with no error.
- R6: A read of lock byte j at LCK_BASE+j (default 0x3800 to 0x3DFF) returns the following in the next cycle: the lock bit of register byte 4j+k at bit 4+k, for k from 0 to 3, and 0 in bits 3:0.
- R7: A supervisor write to lock byte j sets the lock bit of register byte 4j+k to wdata[4+k] where wdata[k] is 1. Where wdata[k] is 0, that lock bit is left unchanged.
- R8: A user-mode write (bus_sup=0) to the lock window changes no lock bit. It raises bus_err in the next cycle.
- R9: The lock bit of a register byte whose PROT bit is 0 stays 0. This holds after a mirror write and after a lock-window write. Writes to such a byte are always accepted.
- R10: A read or write at an address outside the three windows forwards nothing. It returns bus_rdata=0 and bus_err=1 in the next cycle.
- R11: bus_err is high for exactly the one cycle after a failing access, and is 0 in the cycle after an idle cycle or an accepted access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | AW | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_sup | input | 1 | 1 for a supervisor-mode access |
| bus_rdata | output | 8 | Read data, valid in the cycle after a read |
| bus_err | output | 1 | Error response, in the cycle after the access |
| reg_addr | output | IW | Register byte index sent to the peripheral |
| reg_wdata | output | 8 | Write data sent to the peripheral |
| reg_wr | output | 1 | Write strobe to the peripheral, same cycle as bus_wr |
| reg_rd | output | 1 | Read strobe to the peripheral, same cycle as bus_rd |
| reg_rdata | input | 8 | Combinational read data from the peripheral |

## Verification
The peripheral strobes reg_wr, reg_rd, reg_addr and reg_wdata are combinational, so the bench samples them shortly after it drives an access and before the clock edge. bus_err and bus_rdata come from registers, so the bench samples them at the falling edge that follows the capturing rising edge, which is one cycle later. Changes to lock bits take effect at that same rising edge. The bench therefore sees them through a lock-window read issued one access later, with an idle cycle between every two accesses so that no access overlaps the response of the one before.

// File: rtl/reg_softlock_wrap.sv
module reg_softlock_wrap #(
  parameter int AW       = 14,
  parameter int NREG     = 6144,
  parameter int MIR_BASE = 'h2000,
  parameter int LCK_BASE = 'h3800,
  parameter logic [NREG-1:0] PROT = '1,
  localparam int NLB = NREG / 4,
  localparam int IW  = $clog2(NREG),
  localparam int LW  = $clog2(NLB)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_sup,
  output logic [7:0]    bus_rdata,
  output logic          bus_err,
  output logic [IW-1:0] reg_addr,
  output logic [7:0]    reg_wdata,
  output logic          reg_wr,
  output logic          reg_rd,
  input  logic [7:0]    reg_rdata
);
  localparam logic [AW-1:0] DIR_END = AW'(NREG);
  localparam logic [AW-1:0] MIR_LO  = AW'(MIR_BASE);
  localparam logic [AW-1:0] MIR_END = AW'(MIR_BASE + NREG);
  localparam logic [AW-1:0] LCK_LO  = AW'(LCK_BASE);
  localparam logic [AW-1:0] LCK_END = AW'(LCK_BASE + NLB);

  logic [NREG-1:0] lk;
  logic [AW-1:0]   moff, loff;
  logic [LW-1:0]   lidx;
  logic            in_dir, in_mir, in_lck, in_reg, locked, bad, acc;
  logic [7:0]      rd_nxt;

  assign in_dir = bus_addr < DIR_END;
  assign in_mir = bus_addr >= MIR_LO && bus_addr < MIR_END;
  assign in_lck = bus_addr >= LCK_LO && bus_addr < LCK_END;
  assign in_reg = in_dir || in_mir;
  assign moff   = bus_addr - MIR_LO;
  assign loff   = bus_addr - LCK_LO;
  assign lidx   = loff[LW-1:0];

  assign reg_addr  = in_mir ? moff[IW-1:0] : bus_addr[IW-1:0];
  assign reg_wdata = bus_wdata;
  assign locked    = in_reg && lk[reg_addr];
  assign reg_wr    = bus_wr && in_reg && !locked;
  assign reg_rd    = bus_rd && !bus_wr && in_reg;
  assign acc       = bus_wr || bus_rd;

  assign bad = acc && (!(in_reg || in_lck) ||
                       (bus_wr && in_reg && locked) ||
                       (bus_wr && in_lck && !bus_sup));

  assign rd_nxt = in_reg ? reg_rdata :
                  in_lck ? {lk[{lidx, 2'd3}], lk[{lidx, 2'd2}],
                            lk[{lidx, 2'd1}], lk[{lidx, 2'd0}], 4'b0000} :
                  8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk        <= '0;
      bus_err   <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      bus_err   <= bad;
      bus_rdata <= (bus_rd && !bus_wr) ? rd_nxt : 8'h00;
      if (reg_wr && in_mir && PROT[reg_addr])
        lk[reg_addr] <= 1'b1;
      if (bus_wr && in_lck && bus_sup)
        for (int k = 0; k < 4; k++)
          if (bus_wdata[k] && PROT[{lidx, 2'(k)}])
            lk[{lidx, 2'(k)}] <= bus_wdata[4+k];
    end
  end
endmodule

// File: rtl/reg_softlock_chk.sv
module reg_softlock_chk #(
  parameter int AW       = 14,
  parameter int NREG     = 6144,
  parameter int MIR_BASE = 'h2000,
  parameter int LCK_BASE = 'h3800
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic          bus_sup,
  input logic [7:0]    bus_rdata,
  input logic          bus_err,
  input logic          reg_wr,
  input logic          reg_rd
);
  logic in_reg, in_lck, outside;
  assign in_reg  = (int'(bus_addr) < NREG) ||
                   (int'(bus_addr) >= MIR_BASE && int'(bus_addr) < MIR_BASE + NREG);
  assign in_lck  = int'(bus_addr) >= LCK_BASE && int'(bus_addr) < LCK_BASE + NREG / 4;
  assign outside = !in_reg && !in_lck;

  a_r10_outside_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr || bus_rd) && outside |=> bus_err && bus_rdata == 8'h00);
  a_r10_outside_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
    outside |-> !reg_wr && !reg_rd);
  a_r8_user_lock_err: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && in_lck && !bus_sup |=> bus_err);
  a_r4_accepted_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !bus_err);
  a_r5_read_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && in_reg |=> !bus_err);
  a_r11_idle_no_err: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr || bus_rd) |=> !bus_err);
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_wr, reg_rd}));
endmodule

bind reg_softlock_wrap reg_softlock_chk #(
  .AW(AW), .NREG(NREG), .MIR_BASE(MIR_BASE), .LCK_BASE(LCK_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_sup(bus_sup), .bus_rdata(bus_rdata),
  .bus_err(bus_err), .reg_wr(reg_wr), .reg_rd(reg_rd)
);

// File: tb/tb_reg_softlock_wrap.sv
`timescale 1ns/1ps
module tb_reg_softlock_wrap;
  localparam logic [6143:0] TB_PROT = ~({{6143{1'b0}}, 1'b1} << 5);
  localparam int VW = 47;
  // {wr, sup, addr[13:0], wdata[7:0], exp_regwr, exp_err, exp_rdata[7:0], exp_regaddr[12:0]}
  localparam int NV = 27;
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,14'h3800,8'h00, 1'b0,1'b0,8'h00,13'd0},    // R1 locks clear
    {1'b1,1'b0,14'h0004,8'h11, 1'b1,1'b0,8'h00,13'd4},    // R2 direct write
    {1'b0,1'b0,14'h0004,8'h00, 1'b0,1'b0,8'hA1,13'd0},    // R2 direct read
    {1'b1,1'b0,14'h2004,8'h22, 1'b1,1'b0,8'h00,13'd4},    // R3 mirror write locks 4
    {1'b0,1'b0,14'h3801,8'h00, 1'b0,1'b0,8'h10,13'd0},    // R6 lock byte 1
    {1'b1,1'b0,14'h0004,8'h33, 1'b0,1'b1,8'h00,13'd0},    // R4 direct blocked
    {1'b1,1'b1,14'h2004,8'h44, 1'b0,1'b1,8'h00,13'd0},    // R4 mirror blocked
    {1'b0,1'b0,14'h0004,8'h00, 1'b0,1'b0,8'hA1,13'd0},    // R5 read locked
    {1'b0,1'b0,14'h2004,8'h00, 1'b0,1'b0,8'hA1,13'd0},    // R5 mirror read locked
    {1'b1,1'b0,14'h3801,8'h01, 1'b0,1'b1,8'h00,13'd0},    // R8 user lock write
    {1'b0,1'b0,14'h3801,8'h00, 1'b0,1'b0,8'h10,13'd0},    // R8 unchanged
    {1'b1,1'b1,14'h3801,8'h01, 1'b0,1'b0,8'h00,13'd0},    // R7 clear bit0
    {1'b0,1'b0,14'h3801,8'h00, 1'b0,1'b0,8'h00,13'd0},    // R7 cleared
    {1'b1,1'b1,14'h3801,8'hF4, 1'b0,1'b0,8'h00,13'd0},    // R7 only WE2
    {1'b0,1'b0,14'h3801,8'h00, 1'b0,1'b0,8'h40,13'd0},    // R7 only bit 6
    {1'b1,1'b1,14'h3801,8'hF2, 1'b0,1'b0,8'h00,13'd0},    // R9 try lock reg 5
    {1'b1,1'b0,14'h2005,8'h55, 1'b1,1'b0,8'h00,13'd5},    // R9 mirror write reg 5
    {1'b0,1'b0,14'h3801,8'h00, 1'b0,1'b0,8'h40,13'd0},    // R9 bit 5 stays 0
    {1'b1,1'b0,14'h0005,8'h66, 1'b1,1'b0,8'h00,13'd5},    // R9 reg 5 writable
    {1'b1,1'b0,14'h0006,8'h77, 1'b0,1'b1,8'h00,13'd0},    // R4 reg 6 locked by R7
    {1'b0,1'b0,14'h1800,8'h00, 1'b0,1'b1,8'h00,13'd0},    // R10 past direct
    {1'b1,1'b1,14'h3E00,8'hFF, 1'b0,1'b1,8'h00,13'd0},    // R10 past lock window
    {1'b0,1'b0,14'h3FFF,8'h00, 1'b0,1'b1,8'h00,13'd0},    // R10 top address
    {1'b1,1'b0,14'h17FF,8'h88, 1'b1,1'b0,8'h00,13'd6143}, // R2 last direct byte
    {1'b1,1'b0,14'h37FF,8'h99, 1'b1,1'b0,8'h00,13'd6143}, // R3 last mirror byte
    {1'b0,1'b0,14'h3DFF,8'h00, 1'b0,1'b0,8'h80,13'd0},    // R6 last lock byte
    {1'b1,1'b0,14'h17FF,8'hAA, 1'b0,1'b1,8'h00,13'd0}     // R4 last byte locked
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata, reg_wdata, reg_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sup = 1'b0, bus_err, reg_wr, reg_rd;
  logic [12:0] reg_addr;
  int nchk = 0, nfail = 0;
  bit done = 0;
  logic g_wr, g_err; logic [7:0] g_rd, g_wd; logic [12:0] g_ad;

  always #10 clk = ~clk;
  assign reg_rdata = reg_addr[7:0] ^ 8'hA5;

  reg_softlock_wrap #(.PROT(TB_PROT)) dut (.*);

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic access(logic wr, logic sup, logic [13:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_sup = sup; bus_wr = wr; bus_rd = !wr;
    #2;
    g_wr = reg_wr; g_ad = reg_addr; g_wd = reg_wdata;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    g_err = bus_err; g_rd = bus_rdata;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    #35 rst_n = 1'b1;
    @(negedge clk);
    check("R1 err", 16'(bus_err), 16'h0);
    check("R1 rdata", 16'(bus_rdata), 16'h0);
    for (int i = 0; i < NV; i++) begin
      access(VEC[i][46], VEC[i][45], VEC[i][44:31], VEC[i][30:23]);
      check($sformatf("vec%0d reg_wr", i), 16'(g_wr), 16'(VEC[i][22]));
      check($sformatf("vec%0d err", i), 16'(g_err), 16'(VEC[i][21]));
      check($sformatf("vec%0d rdata", i), 16'(g_rd), 16'(VEC[i][20:13]));
      if (VEC[i][22]) begin
        check($sformatf("vec%0d reg_addr", i), 16'(g_ad), 16'(VEC[i][12:0]));
        check($sformatf("vec%0d reg_wdata", i), 16'(g_wd), 16'(VEC[i][30:23]));
      end
    end
    // R11: error lasts one cycle
    access(1'b0, 1'b0, 14'h3F00, 8'h00);
    check("R11 err raised", 16'(g_err), 16'h1);
    @(negedge clk);
    check("R11 err dropped", 16'(bus_err), 16'h0);
    // R1: reset clears all locks
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 err in reset", 16'(bus_err), 16'h0);
    rst_n = 1'b1;
    access(1'b0, 1'b0, 14'h3801, 8'h00);
    check("R1 lock byte 1 cleared", 16'(g_rd), 16'h00);
    access(1'b0, 1'b0, 14'h3DFF, 8'h00);
    check("R1 lock byte last cleared", 16'(g_rd), 16'h00);
    access(1'b1, 1'b0, 14'h0006, 8'h12);
    check("R1 reg 6 writable", 16'(g_wr), 16'h1);
    check("R1 no err", 16'(g_err), 16'h0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule